// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is the device end of a three-wire serial nonvolatile memory with 1024 bits of storage, held in on-chip registers. A host selects it with a chip select, clocks it with a serial clock and shifts instructions in on a data line. Each instruction is a start bit, a two-bit opcode and an address. Write-type instructions also carry a data field. The block answers on a data output that has its own output enable, so the host can model a tri-state pin.

A static organisation input selects the storage shape: 64 words of 16 bits, or 128 bytes. Writes, erases, erase-all and write-all begin when chip select falls. They run for a fixed number of system clocks, and during that time the output reports busy or ready. Reads can continue across word boundaries for as long as the clock keeps running. Host pins are sampled by the system clock, so the serial clock must be several system clocks per phase.

Top module: `mw_eeprom`

## Requirements
- R1: A frame is a 1 start bit, a two-bit opcode and an address, sent MSB first and sampled on serial clock rising edges. The address is 6 bits when `org`=1 and 7 bits when `org`=0. Opcodes: 10 reads, 01 writes, 11 erases one location. With opcode 00, the two top address bits select the command: 11 enables writes, 00 disables writes, 10 erases everything, 01 writes everything. The remaining address bits are ignored.
- R2: After reset, every location reads as all ones, writes are disabled and `do_oe` is 0.
- R3: After the last address bit of a read, the output is enabled and shows one 0 bit. The data then follows MSB first, advancing on each serial clock rising edge.
- R4: While chip select stays high, a read continues with the next address and no extra 0 bit. It wraps from the top address to address 0.
- R5: A write, erase, erase-all or write-all starts programming on the falling edge of chip select, and only when writes are enabled. A write replaces the location without a prior erase. An erased location reads as all ones.
- R6: The enable command allows later programming. The disable command blocks it, and a blocked command leaves the memory and the status output unchanged.
- R7: Once programming has started, the output is enabled whenever chip select is high and shows 0 while busy and 1 when ready. A 1 clocked in while ready disables the output on the next serial clock falling edge.
- R8: Frames sent while programming is in progress have no effect.
- R9: Chip select low in mid-frame abandons the frame. Zeros clocked before a start bit are ignored.
- R10: With `org`=0, address bits 6..1 pick the 16-bit word and address bit 0 picks its upper byte (1) or lower byte (0). Reads and writes move 8 bits.
- R11: Programming keeps the device busy for `PROG_CYCLES` system clocks.
- R12: Write-all stores its data field in every location (both bytes of each word when `org`=0). Erase-all sets every bit to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in |
| org | input | 1 | Organisation: 1 = 16-bit words, 0 = bytes |
| do_data | output | 1 | Serial data out value |
| do_oe | output | 1 | Output enable for do_data |

## Verification
A decoder that lost its bit position shows up at once as a read whose dummy 0 lands one serial clock early or late. The wrong bits then appear in the next data word. A wrong write-enable flag or programming state is only visible later: the status output fails to report busy on the next select, or a readback returns ones or stale data on the following read. A wrong sequential-read address shows as soon as a second word is shifted out, most clearly at the wrap from the top address to 0.

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int WORDS       = 64,
  parameter int WBITS       = 16,
  parameter int PROG_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic org,
  output logic do_data,
  output logic do_oe
);
  localparam int AWW = $clog2(WORDS);
  localparam int AWB = AWW + 1;
  localparam int BW  = WBITS / 2;
  localparam int HW  = AWB + 2;
  localparam int CW  = $clog2(WBITS + HW + 1);
  localparam int PCW = $clog2(PROG_CYCLES + 1);
  localparam logic [1:0] K_WR = 2'd0, K_ER = 2'd1, K_EA = 2'd2, K_WA = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_WDAT, S_PEND, S_READ, S_HOLD} st_t;

  st_t st;
  logic sk_q, cs_q;
  logic [WBITS-1:0] mem [WORDS];
  logic [HW-1:0] hsh;
  logic [CW-1:0] bcnt;
  logic [AWB-1:0] adr;
  logic [1:0] kind;
  logic [WBITS-1:0] wsh, rsh;
  logic dummy, we_en, stat_en, stat_clr, busy;
  logic [PCW-1:0] pcnt;

  wire sk_rise = sk & ~sk_q;
  wire sk_fall = ~sk & sk_q;
  wire st_idle = (st == S_IDLE);

  wire [CW-1:0] hlen = org ? CW'(2 + AWW) : CW'(2 + AWB);
  wire [CW-1:0] dlen = org ? CW'(WBITS) : CW'(BW);
  wire [CW-1:0] bnext = bcnt + 1'b1;
  wire [HW-1:0] hnext = {hsh[HW-2:0], di};
  wire [1:0] nop = org ? hnext[AWW+1:AWW] : hnext[AWB+1:AWB];
  wire [1:0] nsel = org ? hnext[AWW-1:AWW-2] : hnext[AWB-1:AWB-2];
  wire [AWB-1:0] nadr = org ? {1'b0, hnext[AWW-1:0]} : hnext[AWB-1:0];
  wire [AWB-1:0] nxt = org ? {1'b0, adr[AWW-1:0] + 1'b1} : adr + 1'b1;

  wire [AWB-1:0] fa = (st == S_READ) ? nxt : nadr;
  wire [AWW-1:0] fwi = org ? fa[AWW-1:0] : fa[AWB-1:1];
  wire [WBITS-1:0] fm = mem[fwi];
  wire [WBITS-1:0] fword = org ? fm : {(fa[0] ? fm[WBITS-1:BW] : fm[BW-1:0]), {BW{1'b0}}};

  wire [AWW-1:0] wi = org ? adr[AWW-1:0] : adr[AWB-1:1];
  wire [WBITS-1:0] pv = (kind == K_ER || kind == K_EA) ? '1 : wsh;

  assign do_oe = cs & ((st == S_READ) | stat_en);
  assign do_data = (st == S_READ) ? (~dummy & rsh[WBITS-1]) : ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sk_q <= 1'b0; cs_q <= 1'b0;
      hsh <= '0; bcnt <= '0; adr <= '0; kind <= K_WR;
      wsh <= '0; rsh <= '0; dummy <= 1'b0;
      we_en <= 1'b0; stat_en <= 1'b0; stat_clr <= 1'b0;
      busy <= 1'b0; pcnt <= '0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      sk_q <= sk;
      cs_q <= cs;
      if (sk_fall && stat_clr) begin
        stat_en <= 1'b0;
        stat_clr <= 1'b0;
      end
      if (busy) begin
        st <= S_IDLE;
        if (pcnt == PCW'(PROG_CYCLES - 1)) begin
          busy <= 1'b0;
          pcnt <= '0;
          if (kind == K_WR || kind == K_ER) begin
            if (org) mem[wi] <= pv;
            else if (adr[0]) mem[wi][WBITS-1:BW] <= pv[BW-1:0];
            else mem[wi][BW-1:0] <= pv[BW-1:0];
          end else begin
            for (int i = 0; i < WORDS; i++)
              mem[i] <= org ? pv : {pv[BW-1:0], pv[BW-1:0]};
          end
        end else begin
          pcnt <= pcnt + 1'b1;
        end
      end else if (!cs) begin
        if (st == S_PEND && we_en) begin
          busy <= 1'b1;
          stat_en <= 1'b1;
          stat_clr <= 1'b0;
        end
        st <= S_IDLE;
      end else if (sk_rise) begin
        case (st)
          S_IDLE: if (di) begin
            st <= S_HDR;
            bcnt <= '0;
            hsh <= '0;
            if (stat_en) stat_clr <= 1'b1;
          end
          S_HDR: begin
            hsh <= hnext;
            bcnt <= bnext;
            if (bnext == hlen) begin
              bcnt <= '0;
              adr <= nadr;
              case (nop)
                2'b10: begin st <= S_READ; rsh <= fword; dummy <= 1'b1; end
                2'b01: begin st <= S_WDAT; kind <= K_WR; end
                2'b11: begin st <= S_PEND; kind <= K_ER; end
                default: case (nsel)
                  2'b11: begin we_en <= 1'b1; st <= S_HOLD; end
                  2'b00: begin we_en <= 1'b0; st <= S_HOLD; end
                  2'b10: begin st <= S_PEND; kind <= K_EA; end
                  default: begin st <= S_WDAT; kind <= K_WA; end
                endcase
              endcase
            end
          end
          S_WDAT: begin
            wsh <= {wsh[WBITS-2:0], di};
            bcnt <= bnext;
            if (bnext == dlen) st <= S_PEND;
          end
          S_READ: begin
            if (dummy) dummy <= 1'b0;
            else if (bnext == dlen) begin
              bcnt <= '0;
              adr <= nxt;
              rsh <= fword;
            end else begin
              rsh <= {rsh[WBITS-2:0], 1'b0};
              bcnt <= bnext;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk #(
  parameter int PCW = 8,
  parameter int PROG_CYCLES = 200
) (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic busy,
  input logic we_en,
  input logic st_idle,
  input logic [PCW-1:0] pcnt
);
  p_prog_after_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(cs));
  p_prog_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> we_en);
  p_busy_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> st_idle);
  p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt < PCW'(PROG_CYCLES));
  p_cnt_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> pcnt == '0);
endmodule

bind mw_eeprom mw_eeprom_chk #(.PCW(PCW), .PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .busy(busy), .we_en(we_en),
  .st_idle(st_idle), .pcnt(pcnt)
);

// File: tb/tb_mw_eeprom.sv
`timescale 1ns/1ps
module tb_mw_eeprom;
  localparam int PROG = 200;

  logic clk = 0, rst_n = 0, cs = 0, sk = 0, di = 0, org = 1;
  logic do_data, do_oe;
  int vectors = 0, miscompares = 0, cyc = 0;

  typedef struct { logic oe; logic b; string tag; } exp_t;
  exp_t q[$];

  mw_eeprom #(.PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org(org),
    .do_data(do_data), .do_oe(do_oe));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge sk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      vectors++;
      if (do_oe !== e.oe || (e.oe && do_data !== e.b)) begin
        miscompares++;
        $display("FAIL %s: got oe=%b d=%b expected oe=%b d=%b", e.tag, do_oe, do_data, e.oe, e.b);
      end
    end
  end

  task automatic chk(input logic act, input logic expv, input string tag);
    vectors++;
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b", tag, act, expv);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    @(negedge clk) di = b;
    clks(2); sk = 1;
    clks(4); sk = 0;
    clks(2);
  endtask

  task automatic sel();
    @(negedge clk) cs = 1;
    clks(2);
  endtask

  task automatic desel();
    @(negedge clk) begin sk = 0; cs = 0; end
    clks(3);
  endtask

  task automatic cmd(input int aw, input logic [1:0] op, input int a);
    pulse(1); pulse(op[1]); pulse(op[0]);
    for (int i = aw - 1; i >= 0; i--) pulse(a[i]);
  endtask

  task automatic send(input logic [15:0] d, input int n);
    for (int i = n - 1; i >= 0; i--) pulse(d[i]);
  endtask

  task automatic prog(input int aw, input logic [1:0] op, input int a,
                      input int dw, input logic [15:0] d);
    sel(); cmd(aw, op, a);
    if (dw > 0) send(d, dw);
    desel(); clks(PROG + 20);
  endtask

  task automatic rd(input int aw, input int a, input int n, input int dw,
                    input logic [15:0] e0, input logic [15:0] e1, input int lz, input string tag);
    sel();
    for (int i = 0; i < lz; i++) pulse(0);
    pulse(1); pulse(1); pulse(0);
    for (int i = aw - 1; i >= 1; i--) pulse(a[i]);
    q.push_back('{1'b1, 1'b0, tag});
    pulse(a[0]);
    for (int w = 0; w < n; w++)
      for (int j = dw - 1; j >= 0; j--) begin
        q.push_back('{1'b1, (w == 0) ? e0[j] : e1[j], tag});
        pulse(0);
      end
    desel();
  endtask

  initial begin
    #(20ns * 150000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int t0;
    clks(3); rst_n = 1; clks(2);
    chk(do_oe, 1'b0, "R2 reset output disabled");

    prog(6, 2'b01, 5, 16, 16'hA5C3);
    sel(); chk(do_oe, 1'b0, "R6 no status after blocked write"); desel();
    rd(6, 5, 1, 16, 16'hFFFF, 0, 0, "R2 blocked write leaves ones");

    sel(); cmd(6, 2'b00, 6'b110000); desel();

    sel(); cmd(6, 2'b01, 5); send(16'hA5C3, 16);
    @(negedge clk) begin sk = 0; cs = 0; end
    t0 = cyc;
    clks(2); cs = 1; clks(2);
    chk(do_oe, 1'b1, "R7 status enabled");
    chk(do_data, 1'b0, "R7 busy reads 0");
    cmd(6, 2'b00, 6'b000000);
    while (cyc < t0 + PROG - 10) @(negedge clk);
    chk(do_data, 1'b0, "R11 still busy before cycle count");
    while (cyc < t0 + PROG + 10) @(negedge clk);
    chk(do_data, 1'b1, "R11 ready after cycle count");
    chk(do_oe, 1'b1, "R7 ready status enabled");
    pulse(1);
    chk(do_oe, 1'b0, "R7 dummy 1 releases output");
    desel();

    rd(6, 5, 1, 16, 16'hA5C3, 0, 0, "R3 read after write");
    prog(6, 2'b01, 0, 16, 16'h8001);
    prog(6, 2'b01, 63, 16, 16'h0F0F);
    rd(6, 63, 2, 16, 16'h0F0F, 16'h8001, 0, "R4 R8 sequential wrap");
    prog(6, 2'b01, 5, 16, 16'h1111);
    rd(6, 5, 1, 16, 16'h1111, 0, 0, "R5 overwrite without erase");
    prog(6, 2'b11, 5, 0, 0);
    rd(6, 5, 1, 16, 16'hFFFF, 0, 0, "R5 erase gives ones");

    sel(); pulse(1); pulse(1); pulse(0); pulse(0); desel();
    rd(6, 0, 1, 16, 16'h8001, 0, 3, "R9 abort and leading zeros");

    org = 0; clks(2);
    prog(7, 2'b01, 11, 8, 16'h003C);
    rd(7, 11, 1, 8, 16'h003C, 0, 0, "R10 byte read upper");
    rd(7, 10, 1, 8, 16'h00FF, 0, 0, "R10 byte read lower");
    rd(7, 127, 2, 8, 16'h000F, 16'h0001, 0, "R4 R10 byte wrap");
    org = 1; clks(2);
    rd(6, 5, 1, 16, 16'h3CFF, 0, 0, "R10 word view of byte write");

    prog(6, 2'b00, 6'b010000, 16, 16'h5A5A);
    rd(6, 40, 2, 16, 16'h5A5A, 16'h5A5A, 0, "R12 write all");
    org = 0; clks(2);
    prog(7, 2'b00, 7'b0100000, 8, 16'h00C6);
    org = 1; clks(2);
    rd(6, 9, 1, 16, 16'hC6C6, 0, 0, "R12 byte write all");
    prog(6, 2'b00, 6'b100000, 0, 0);
    rd(6, 17, 2, 16, 16'hFFFF, 16'hFFFF, 0, "R12 erase all");
    rd(1 + 5, 0, 1, 16, 16'hFFFF, 0, 0, "R1 R12 erase all address 0");

    sel(); cmd(6, 2'b00, 6'b001111); desel();
    prog(6, 2'b01, 7, 16, 16'h0000);
    sel(); chk(do_oe, 1'b0, "R6 disabled write shows no status"); desel();
    rd(6, 7, 1, 16, 16'hFFFF, 0, 0, "R6 disable blocks write");

    clks(10);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule